// File: doc/BRIEF.md
# Reference Pilot Least-Squares Estimator

This block walks one OFDM symbol of frequency-domain subcarriers and produces a raw channel estimate at every cell reference pilot it holds. The subcarriers come from an FFT that ran after cyclic prefix removal. They sit in a shared symbol memory that also holds the other symbols of the subframe. A caller pulses `start_i` with the symbol number inside the subframe, a pilot frequency offset and the base address of that symbol in memory. For a pilot-bearing symbol, the block reads one memory word per pilot, with the address climbing in steps of six. It pairs each word with the next value from an incoming stream of known QPSK pilot symbols and emits the least-squares product Y·conj(X) on a valid/ready stream. Each result is tagged with its subcarrier and symbol numbers.

Symbols without pilots are finished at once: no memory read, no output, only the completion pulse. The estimates feed the frequency and time interpolators that sit downstream. Pilot sequence generation, MMSE weighting and the FFT are outside this block.

Top module: `pilot_ls_est`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, `est_valid_o`, `done_o`, `mem_req_o` and `ref_ready_o` are all 0.
- R2: A symbol number s (0..13) carries pilots only when s mod 7 is 0 or 4, that is s in {0, 4, 7, 11}. An accepted start for any other s issues no memory read and no estimate, and raises `done_o` for one cycle in the cycle after the start edge.
- R3: For a pilot symbol with offset `shift_i` (0..5), the block reads subcarriers k = 6m + shift for m = 0 .. N_PILOT-1, in ascending m. Each read address is (base + k) modulo 2^ADDR_W, so each request is 6 above the previous one within the symbol.
- R4: A memory word carries the I part in bits [2*IQ_W-1:IQ_W] and the Q part in bits [IQ_W-1:0], both two's complement. Pilot code bit 1 set means the real part of the pilot is negative; bit 0 set means the imaginary part is negative (sa, sb = ±1). The estimate is I = (sa·yI + sb·yQ) >>> 1 and Q = (sa·yQ − sb·yI) >>> 1, with an arithmetic shift.
- R5: A result outside the IQ_W-bit signed range saturates to the nearest limit (for example +32767 when both inputs are −32768 and the code is 3).
- R6: Each estimate carries its subcarrier k on `est_sc_o` and the symbol number given at start on `est_sym_o`. Estimates leave in ascending k.
- R7: While `est_valid_o` is high and `est_ready_i` is low, `est_valid_o` and all estimate fields hold their values.
- R8: Exactly one pilot code is taken per estimate, on a cycle where `ref_valid_i` and `ref_ready_o` are both high. The m-th code taken within a symbol is used for pilot m.
- R9: A pilot symbol yields exactly N_PILOT estimates. `done_o` pulses for one cycle in the cycle after the last estimate is transferred, and at no other time.
- R10: A start pulse arriving after an accepted start, up to and including the cycle in which `done_o` is high, is ignored. The running symbol's addresses, tags and count are unchanged, and no further work follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one symbol |
| sym_idx_i | input | 4 | Symbol number within the subframe, 0..13 |
| shift_i | input | 3 | Pilot frequency offset, 0..5 |
| base_addr_i | input | ADDR_W | Memory address of subcarrier 0 of the symbol |
| mem_req_o | output | 1 | Read strobe to the symbol memory |
| mem_addr_o | output | ADDR_W | Read address |
| mem_rdata_i | input | 2*IQ_W | Read data, valid one cycle after the strobe |
| ref_valid_i | input | 1 | Known pilot code available |
| ref_qpsk_i | input | 2 | Pilot code: bit 1 real sign, bit 0 imaginary sign |
| ref_ready_o | output | 1 | Pilot code taken this cycle if valid |
| est_valid_o | output | 1 | Estimate valid |
| est_ready_i | input | 1 | Downstream accepts the estimate |
| est_i_o | output | IQ_W | Estimate real part |
| est_q_o | output | IQ_W | Estimate imaginary part |
| est_sc_o | output | SC_W | Subcarrier number of the estimate |
| est_sym_o | output | 4 | Symbol number of the estimate |
| done_o | output | 1 | One-cycle pulse at the end of a symbol |

## Verification
The bench drives the four pilot symbols and several non-pilot ones, with every offset and with bases near the top of the address space. A design that decoded the slot position wrongly would either emit estimates for a data symbol or stay silent on a pilot one. A wrong stride or missing wrap would show up in the address sequence. Extreme samples of −32768 and +32767 against all four pilot codes target the saturation: without it, the result would wrap to the opposite sign. Random gaps on both the pilot stream and the output ready check two things: that backpressure never drops or reorders an estimate or a pilot code, and that a start pulse injected mid-symbol neither retags the outputs nor launches a second run.

// File: rtl/pilot_pkg.sv
package pilot_pkg;
  localparam int SYM_W         = 4;
  localparam int SYMS_PER_SLOT = 7;
  localparam int SLOTS         = 2;
  localparam int PILOT_POS_A   = 0;
  localparam int PILOT_POS_B   = 4;
  localparam int PILOT_STRIDE  = 6;
  localparam int SHIFT_W       = $clog2(PILOT_STRIDE);

  typedef enum logic [0:0] {SCH_IDLE, SCH_ISSUE} sch_state_e;

  function automatic logic is_pilot_sym(input logic [SYM_W-1:0] s);
    int pos;
    pos = int'(s) % SYMS_PER_SLOT;
    return (int'(s) < SLOTS * SYMS_PER_SLOT) && (pos == PILOT_POS_A || pos == PILOT_POS_B);
  endfunction
endpackage

// File: rtl/pilot_fifo.sv
module pilot_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             nempty_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic             do_push, do_pop;

  assign do_pop  = pop_i && (cnt_o != '0);
  assign do_push = push_i && ((int'(cnt_o) < DEPTH) || do_pop);

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_o <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_o <= cnt_o + CNT_W'(1);
        2'b01:   cnt_o <= cnt_o - CNT_W'(1);
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  assign dout_o   = mem_q[rd_q];
  assign nempty_o = (cnt_o != '0);
endmodule

// File: rtl/pilot_sched.sv
module pilot_sched
  import pilot_pkg::*;
#(
  parameter int N_PILOT    = 200,
  parameter int ADDR_W     = 15,
  parameter int SC_W       = 11,
  parameter int FIFO_DEPTH = 3,
  parameter int CNT_W      = 2,
  localparam int M_W       = $clog2(N_PILOT + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [CNT_W-1:0]   fifo_cnt_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               tag_vld_o,
  output logic [SC_W-1:0]    tag_sc_o,
  output logic               tag_last_o
);
  sch_state_e        state_q;
  logic [M_W-1:0]    m_q;
  logic [SC_W-1:0]   k_q;
  logic [ADDR_W-1:0] base_q;
  logic              last_m;

  // credit: fifo entries plus the read in flight must fit the fifo
  assign mem_req_o  = (state_q == SCH_ISSUE) &&
                      (int'(fifo_cnt_i) + int'(tag_vld_o) < FIFO_DEPTH);
  assign mem_addr_o = base_q + ADDR_W'(k_q);
  assign last_m     = (m_q == M_W'(N_PILOT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SCH_IDLE;
      m_q        <= '0;
      k_q        <= '0;
      base_q     <= '0;
      tag_vld_o  <= 1'b0;
      tag_sc_o   <= '0;
      tag_last_o <= 1'b0;
    end else begin
      tag_vld_o <= mem_req_o;
      if (mem_req_o) begin
        tag_sc_o   <= k_q;
        tag_last_o <= last_m;
      end
      case (state_q)
        SCH_IDLE: begin
          if (start_i) begin
            state_q <= SCH_ISSUE;
            m_q     <= '0;
            k_q     <= SC_W'(shift_i);
            base_q  <= base_i;
          end
        end
        SCH_ISSUE: begin
          if (mem_req_o) begin
            m_q <= m_q + M_W'(1);
            k_q <= k_q + SC_W'(PILOT_STRIDE);
            if (last_m) state_q <= SCH_IDLE;
          end
        end
        default: state_q <= SCH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pilot_ls_mult.sv
module pilot_ls_mult #(
  parameter int IQ_W = 16
) (
  input  logic [IQ_W-1:0] y_i_i,
  input  logic [IQ_W-1:0] y_q_i,
  input  logic [1:0]      code_i,
  output logic [IQ_W-1:0] h_i_o,
  output logic [IQ_W-1:0] h_q_o
);
  localparam int W2 = IQ_W + 2;
  localparam logic signed [W2-1:0] MAX_V = W2'((1 <<< (IQ_W - 1)) - 1);
  localparam logic signed [W2-1:0] MIN_V = -MAX_V - W2'(1);

  logic signed [W2-1:0] yi, yq, a, b, c, d, ti, tq, si, sq;

  function automatic logic [IQ_W-1:0] sat(input logic signed [W2-1:0] v);
    if (v > MAX_V)      return MAX_V[IQ_W-1:0];
    else if (v < MIN_V) return MIN_V[IQ_W-1:0];
    else                return v[IQ_W-1:0];
  endfunction

  assign yi = {{2{y_i_i[IQ_W-1]}}, y_i_i};
  assign yq = {{2{y_q_i[IQ_W-1]}}, y_q_i};
  // unit QPSK: multiply by conj(X) reduces to sign flips
  assign a  = code_i[1] ? -yi : yi;
  assign b  = code_i[0] ? -yq : yq;
  assign c  = code_i[1] ? -yq : yq;
  assign d  = code_i[0] ? -yi : yi;
  assign ti = a + b;
  assign tq = c - d;
  assign si = ti >>> 1;
  assign sq = tq >>> 1;
  assign h_i_o = sat(si);
  assign h_q_o = sat(sq);
endmodule

// File: rtl/pilot_ls_out.sv
module pilot_ls_out #(
  parameter int IQ_W  = 16,
  parameter int SC_W  = 11,
  parameter int SYM_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ent_vld_i,
  input  logic [2*IQ_W-1:0] ent_y_i,
  input  logic [SC_W-1:0]   ent_sc_i,
  input  logic              ent_last_i,
  input  logic [SYM_W-1:0]  sym_i,
  output logic              pop_o,
  input  logic              ref_valid_i,
  input  logic [1:0]        ref_qpsk_i,
  output logic              ref_ready_o,
  output logic              est_valid_o,
  input  logic              est_ready_i,
  output logic [IQ_W-1:0]   est_i_o,
  output logic [IQ_W-1:0]   est_q_o,
  output logic [SC_W-1:0]   est_sc_o,
  output logic [SYM_W-1:0]  est_sym_o,
  output logic              est_last_o
);
  logic            can_load;
  logic [IQ_W-1:0] h_i, h_q;

  pilot_ls_mult #(.IQ_W(IQ_W)) u_mult (
    .y_i_i  (ent_y_i[2*IQ_W-1:IQ_W]),
    .y_q_i  (ent_y_i[IQ_W-1:0]),
    .code_i (ref_qpsk_i),
    .h_i_o  (h_i),
    .h_q_o  (h_q)
  );

  assign can_load    = !est_valid_o || est_ready_i;
  assign ref_ready_o = ent_vld_i && can_load;
  assign pop_o       = ref_ready_o && ref_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      est_valid_o <= 1'b0;
      est_i_o     <= '0;
      est_q_o     <= '0;
      est_sc_o    <= '0;
      est_sym_o   <= '0;
      est_last_o  <= 1'b0;
    end else if (pop_o) begin
      est_valid_o <= 1'b1;
      est_i_o     <= h_i;
      est_q_o     <= h_q;
      est_sc_o    <= ent_sc_i;
      est_sym_o   <= sym_i;
      est_last_o  <= ent_last_i;
    end else if (est_ready_i) begin
      est_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pilot_ls_est.sv
module pilot_ls_est
  import pilot_pkg::*;
#(
  parameter int N_PILOT    = 200,
  parameter int IQ_W       = 16,
  parameter int ADDR_W     = 15,
  parameter int FIFO_DEPTH = 3,
  localparam int SC_W      = $clog2(PILOT_STRIDE * N_PILOT),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int ENT_W     = 2 * IQ_W + SC_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SYM_W-1:0]   sym_idx_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [ADDR_W-1:0]  base_addr_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [2*IQ_W-1:0]  mem_rdata_i,
  input  logic               ref_valid_i,
  input  logic [1:0]         ref_qpsk_i,
  output logic               ref_ready_o,
  output logic               est_valid_o,
  input  logic               est_ready_i,
  output logic [IQ_W-1:0]    est_i_o,
  output logic [IQ_W-1:0]    est_q_o,
  output logic [SC_W-1:0]    est_sc_o,
  output logic [SYM_W-1:0]   est_sym_o,
  output logic               done_o
);
  logic             busy_q, start_acc, pilot_now;
  logic [SYM_W-1:0] sym_q;
  logic             tag_vld, tag_last, pop, ent_vld, est_last;
  logic [SC_W-1:0]  tag_sc;
  logic [ENT_W-1:0] ent;
  logic [CNT_W-1:0] fifo_cnt;

  assign start_acc = start_i && !busy_q;
  assign pilot_now = is_pilot_sym(sym_idx_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sym_q  <= '0;
      done_o <= 1'b0;
    end else begin
      if (start_acc)   busy_q <= 1'b1;
      else if (done_o) busy_q <= 1'b0;
      if (start_acc) sym_q <= sym_idx_i;
      done_o <= (start_acc && !pilot_now) || (est_valid_o && est_ready_i && est_last);
    end
  end

  pilot_sched #(
    .N_PILOT(N_PILOT), .ADDR_W(ADDR_W), .SC_W(SC_W),
    .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
  ) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_acc && pilot_now),
    .shift_i    (shift_i),
    .base_i     (base_addr_i),
    .fifo_cnt_i (fifo_cnt),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .tag_vld_o  (tag_vld),
    .tag_sc_o   (tag_sc),
    .tag_last_o (tag_last)
  );

  pilot_fifo #(.W(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (tag_vld),
    .din_i    ({mem_rdata_i, tag_sc, tag_last}),
    .pop_i    (pop),
    .dout_o   (ent),
    .nempty_o (ent_vld),
    .cnt_o    (fifo_cnt)
  );

  pilot_ls_out #(.IQ_W(IQ_W), .SC_W(SC_W), .SYM_W(SYM_W)) u_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ent_vld_i   (ent_vld),
    .ent_y_i     (ent[ENT_W-1 -: 2*IQ_W]),
    .ent_sc_i    (ent[SC_W:1]),
    .ent_last_i  (ent[0]),
    .sym_i       (sym_q),
    .pop_o       (pop),
    .ref_valid_i (ref_valid_i),
    .ref_qpsk_i  (ref_qpsk_i),
    .ref_ready_o (ref_ready_o),
    .est_valid_o (est_valid_o),
    .est_ready_i (est_ready_i),
    .est_i_o     (est_i_o),
    .est_q_o     (est_q_o),
    .est_sc_o    (est_sc_o),
    .est_sym_o   (est_sym_o),
    .est_last_o  (est_last)
  );
endmodule

// File: rtl/pilot_ls_est_chk.sv
module pilot_ls_est_chk
  import pilot_pkg::*;
#(
  parameter int IQ_W   = 16,
  parameter int ADDR_W = 15,
  parameter int SC_W   = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              est_valid_o,
  input logic              est_ready_i,
  input logic [IQ_W-1:0]   est_i_o,
  input logic [IQ_W-1:0]   est_q_o,
  input logic [SC_W-1:0]   est_sc_o,
  input logic [SYM_W-1:0]  est_sym_o,
  input logic              done_o,
  input logic              busy_q
);
  logic              have_last;
  logic [ADDR_W-1:0] last_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_last <= 1'b0;
      last_addr <= '0;
    end else if (done_o) begin
      have_last <= 1'b0;
    end else if (mem_req_o) begin
      have_last <= 1'b1;
      last_addr <= mem_addr_o;
    end
  end

  AST_ADDR_STRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && have_last) |-> mem_addr_o == last_addr + ADDR_W'(PILOT_STRIDE)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (est_valid_o && !est_ready_i) |=>
      (est_valid_o && $stable({est_i_o, est_q_o, est_sc_o, est_sym_o}))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9

  AST_PILOT_SYM_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    est_valid_o |-> is_pilot_sym(est_sym_o)); // R2

  AST_REQ_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_q); // R10
endmodule

bind pilot_ls_est pilot_ls_est_chk #(.IQ_W(IQ_W), .ADDR_W(ADDR_W), .SC_W(SC_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .est_valid_o (est_valid_o),
  .est_ready_i (est_ready_i),
  .est_i_o     (est_i_o),
  .est_q_o     (est_q_o),
  .est_sc_o    (est_sc_o),
  .est_sym_o   (est_sym_o),
  .done_o      (done_o),
  .busy_q      (busy_q)
);

// File: tb/tb_pilot_ls_est.sv
`timescale 1ns/1ps
module tb_pilot_ls_est;
  localparam int N_PILOT = 200;
  localparam int IQ_W    = 16;
  localparam int ADDR_W  = 15;
  localparam int SC_W    = $clog2(6 * N_PILOT);

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0;
  logic [3:0]        sym_idx_i = '0;
  logic [2:0]        shift_i = '0;
  logic [ADDR_W-1:0] base_addr_i = '0;
  logic              mem_req_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [2*IQ_W-1:0] mem_rdata_i = '0;
  logic              ref_valid_i = 1'b0;
  logic [1:0]        ref_qpsk_i = '0;
  logic              ref_ready_o;
  logic              est_valid_o;
  logic              est_ready_i = 1'b0;
  logic [IQ_W-1:0]   est_i_o, est_q_o;
  logic [SC_W-1:0]   est_sc_o;
  logic [3:0]        est_sym_o;
  logic              done_o;

  int checks = 0;
  int errors = 0;
  int cur_mode = 0;
  int unsigned cur_salt = 0;
  logic [1:0] ref_tab [N_PILOT];
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  pilot_ls_est dut (.*);

  function automatic logic [31:0] memf(input int addr);
    int unsigned ai, aq;
    case (cur_mode)
      1: return 32'h8000_8000;
      2: return 32'h7FFF_8000;
      default: begin
        ai = (addr * 40503) ^ cur_salt;
        aq = (addr * 31321) ^ (cur_salt >> 16);
        return {ai[15:0], aq[15:0]};
      end
    endcase
  endfunction

  always @(posedge clk_i) if (mem_req_o) mem_rdata_i <= memf(int'(mem_addr_o));

  function automatic int clamp(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic bit pilot_sym(input int s);
    return (s < 14) && ((s % 7) == 0 || (s % 7) == 4);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_symbol(input int sym, input int shift, input int base, input int mode,
                            input int rdy_pct, input int ref_pct, input bit poke);
    int got = 0, refp = 0, nreq = 0, cyc = 0, exp_n;
    bit seen_done = 0;
    exp_n = pilot_sym(sym) ? N_PILOT : 0;
    for (int m = 0; m < N_PILOT; m++) ref_tab[m] = 2'($urandom % 4);
    cur_mode = mode;
    cur_salt = $urandom;
    @(negedge clk_i);
    start_i = 1'b1; sym_idx_i = 4'(sym); shift_i = 3'(shift); base_addr_i = ADDR_W'(base);
    @(negedge clk_i);
    start_i = 1'b0;
    while (!seen_done && cyc < 20000) begin
      cyc++;
      if (poke && cyc == 5) begin
        start_i = 1'b1; sym_idx_i = (sym == 0) ? 4'd4 : 4'd0;
        shift_i = 3'((shift + 1) % 6); base_addr_i = ADDR_W'(base + 3);
      end else start_i = 1'b0;
      est_ready_i = (($urandom % 100) < rdy_pct);
      ref_valid_i = (refp < N_PILOT) && (($urandom % 100) < ref_pct);
      ref_qpsk_i  = ref_tab[(refp < N_PILOT) ? refp : 0];
      #1;
      if (done_o) begin
        seen_done = 1;
        chk(got == exp_n, "R9", "estimates before done", got, exp_n);
      end
      if (mem_req_o) begin
        int ea = (base + shift + 6 * nreq) % (1 << ADDR_W);
        chk(int'(mem_addr_o) == ea, "R3", "read address", int'(mem_addr_o), ea);
        nreq++;
      end
      if (ref_valid_i && ref_ready_o) refp++;
      if (est_valid_o && est_ready_i) begin
        int sc = shift + 6 * got;
        logic [31:0] y = memf((base + sc) % (1 << ADDR_W));
        int yi = int'($signed(y[31:16]));
        int yq = int'($signed(y[15:0]));
        int sa = ref_tab[got][1] ? -1 : 1;
        int sb = ref_tab[got][0] ? -1 : 1;
        int ei = clamp((sa * yi + sb * yq) >>> 1);
        int eq = clamp((sa * yq - sb * yi) >>> 1);
        chk(got < exp_n, "R2", "estimate count", got, exp_n);
        chk(int'($signed(est_i_o)) == ei, (mode != 0) ? "R5" : "R4", "real part",
            int'($signed(est_i_o)), ei);
        chk(int'($signed(est_q_o)) == eq, (mode != 0) ? "R5" : "R4", "imag part",
            int'($signed(est_q_o)), eq);
        chk(int'(est_sc_o) == sc, "R6", "subcarrier tag", int'(est_sc_o), sc);
        chk(int'(est_sym_o) == sym, "R6", "symbol tag", int'(est_sym_o), sym);
        got++;
      end
      @(negedge clk_i);
    end
    start_i = 1'b0; ref_valid_i = 1'b0;
    chk(seen_done, "R9", "done seen", int'(seen_done), 1);
    chk(got == exp_n, "R9", "estimate total", got, exp_n);
    chk(refp == exp_n, "R8", "pilot codes taken", refp, exp_n);
    chk(nreq == exp_n, "R2", "memory reads", nreq, exp_n);
    est_ready_i = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #1;
      chk(!est_valid_o && !done_o && !mem_req_o, poke ? "R10" : "R9", "idle after done",
          int'({est_valid_o, done_o, mem_req_o}), 0);
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    repeat (3) @(negedge clk_i);
    chk({est_valid_o, done_o, mem_req_o, ref_ready_o} == 4'b0, "R1", "outputs in reset",
        int'({est_valid_o, done_o, mem_req_o, ref_ready_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({est_valid_o, done_o, mem_req_o, ref_ready_o} == 4'b0, "R1", "outputs after reset",
        int'({est_valid_o, done_o, mem_req_o, ref_ready_o}), 0);

    run_symbol(0, 0, 0, 0, 100, 100, 0);          // R3 R4 full rate
    run_symbol(4, 5, 1500, 0, 40, 60, 1);         // R7 R8 R10 backpressure and ignored start
    run_symbol(2, 3, 200, 0, 100, 100, 0);        // R2 data symbol
    run_symbol(13, 1, 0, 0, 100, 100, 0);         // R2 last data symbol
    run_symbol(11, 3, 32000, 1, 70, 70, 0);       // R5 saturation, R3 wrap
    run_symbol(7, 1, 9000, 2, 60, 90, 1);         // R5 opposite extremes
    for (int i = 0; i < 8; i++) begin
      int s = int'($urandom % 14);
      run_symbol(s, int'($urandom % 6), int'($urandom % 32768), 0,
                 20 + int'($urandom % 81), 20 + int'($urandom % 81), i[0]);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule